// File: doc/BRIEF.md
# Channel-Indexed DMA Register Bank

This block is the software-visible register file of a twenty-channel DMA engine. A single register bus reaches a small set of global registers and one shared window of five per-channel registers. Which channel the window reaches is set by a channel-select register, so each channel's control, descriptor ring base, ring length, interrupt status and interrupt enable sit behind the same five offsets. The block does not move data. It drives each channel's configuration to the datapath as flat output vectors and takes per-channel interrupt-cause pulses back from it.

Channel reset and engine reset are self-clearing bits. Software sets one and polls until it reads back zero. Interrupt status bits are cleared by writing ones. A registered interrupt output combines every channel's pending, enabled causes, gated by a per-channel global enable mask. The block also keeps a per-channel descriptor index that advances on descriptor-complete events. Polling control and banked port control registers are plain storage.

Top module: `dma_chan_regbank`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq`, `ch_on`, `ch_idx`, `poll_en` and `poll_div4` are 0. Read data is registered and appears the cycle after `bus_ren`.
- R2: Offset 0x18 selects the channel. It reads back the low 5 bits of the last value written. Offsets 0x1C, 0x20, 0x24, 0x28 and 0x2C reach only the selected channel's registers.
- R3: Channel control (0x1C) has these fields: bit 0 = channel on (drives `ch_on`), bit 8 = transmit direction (`ch_tx`), bits 17:16 = weight (`ch_weight`). All other bits read 0.
- R4: Writing 1 to control bit 1 starts a channel reset. The bit reads 1 on exactly RST_CYCLES (4) consecutive reads that follow the write, then reads 0. When the reset completes, it clears that channel's on bit, status and descriptor index, and keeps direction and weight.
- R5: Descriptor base (0x20) stores bits 31:3 and reads bits 2:0 as 0. Descriptor length (0x24) stores LEN_W (8) bits. Both drive `ch_base` and `ch_len`.
- R6: Interrupt status (0x28) is 7 bits wide. Bit k of a channel's `ch_cause` slice sets status bit k for k = 1..6, and cause bit 0 is ignored. Writing 1 to a status bit clears it. A cause arriving in the same cycle as its clear wins. Writing 0x7E clears every cause.
- R7: Interrupt enable (0x2C) stores bits 6:1 only. Bit 3 is the descriptor-complete cause.
- R8: Cause bit 3 on a channel that is on advances `ch_idx` by one, wrapping to 0 after LEN-1. A channel that is off does not advance. A length of 0 keeps the index at 0. Writing the length resets the index to 0.
- R9: `irq` is registered. One cycle after the state changes it equals the OR over channels n of (status AND enable nonzero) AND global enable bit n, where the global enable is at 0xF4, bit n for channel n. Writing 0 to 0xF4 masks every channel.
- R10: While the select value is 20 or more, writes to 0x1C–0x2C have no effect and reads of them return 0.
- R11: Global control (0xF4 excluded; offset 0x10) bit 0 starts an engine reset. The bit reads 1 for RST_CYCLES reads, then 0. Completion clears every channel's on bit, status and index. Bits 31:1 of 0x10 are plain storage. Polling control (0x14) is fully stored: bit 31 drives `poll_en` and bit 6 drives `poll_div4`.
- R12: Port select (0x40) and port control (0x44) hold one control word per port for 5 ports. A port select of 5 or more makes 0x44 writes ignored and reads 0. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ch_cause | input | 7*NCH | Per-channel cause pulses, 7-bit slice per channel |
| ch_on | output | NCH | Channel on bits |
| ch_tx | output | NCH | Transmit direction bits |
| ch_weight | output | 2*NCH | Channel weights |
| ch_base | output | 32*NCH | Descriptor ring bases |
| ch_len | output | LEN_W*NCH | Descriptor ring lengths |
| ch_idx | output | LEN_W*NCH | Current descriptor indices |
| poll_en | output | 1 | Descriptor polling enable |
| poll_div4 | output | 1 | Divide-by-4 polling clock select |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a cause pulse and a write-1-to-clear landing on the same status bit in the same cycle. The stimulus first clears that bit. It then drives the cause slice and the status write in one shared cycle and checks that the bit survives. The reset-in-progress windows are also hard to observe, because the read data path is registered. The bench issues a read every cycle straight after the reset write, counts the reads that return a set busy bit, and compares the count with RST_CYCLES. It then confirms that the index, status and on bit were cleared while direction and weight were kept.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFF_GCTRL = 8'h10;
  localparam logic [7:0] OFF_POLL  = 8'h14;
  localparam logic [7:0] OFF_CSEL  = 8'h18;
  localparam logic [7:0] OFF_CCTL  = 8'h1C;
  localparam logic [7:0] OFF_CBASE = 8'h20;
  localparam logic [7:0] OFF_CLEN  = 8'h24;
  localparam logic [7:0] OFF_CSTAT = 8'h28;
  localparam logic [7:0] OFF_CIEN  = 8'h2C;
  localparam logic [7:0] OFF_PSEL  = 8'h40;
  localparam logic [7:0] OFF_PCTL  = 8'h44;
  localparam logic [7:0] OFF_GIEN  = 8'hF4;

  localparam int CTL_ON    = 0;
  localparam int CTL_RST   = 1;
  localparam int CTL_TX    = 8;
  localparam int CTL_WT_LO = 16;

  localparam int         STAT_W    = 7;
  localparam logic [6:0] STAT_MASK = 7'h7E;
  localparam int         DESC_DONE = 3;

  typedef struct packed {
    logic we_ctl;
    logic we_base;
    logic we_len;
    logic we_stat;
    logic we_ien;
  } chan_wr_t;
endpackage

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  chan_wr_t          wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [STAT_W-1:0] cause,
  input  logic              eng_clr,
  output logic              on_o,
  output logic              tx_o,
  output logic [1:0]        wt_o,
  output logic [REG_W-1:0]  base_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [LEN_W-1:0]  idx_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] ien_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              on_q, tx_q;
  logic [1:0]        wt_q;
  logic [REG_W-4:0]  base_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [STAT_W-1:0] stat_q, ien_q;
  logic              busy, done, wipe, adv;
  logic [STAT_W-1:0] clr_bits;

  assign busy     = (cnt_q != '0);
  assign done     = busy && (cnt_q == CNT_W'(1));
  assign wipe     = done || eng_clr;
  assign adv      = on_q && cause[DESC_DONE];
  assign clr_bits = wr.we_stat ? wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      on_q   <= 1'b0;
      tx_q   <= 1'b0;
      wt_q   <= '0;
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr.we_ctl && wdata[CTL_RST] && !busy)
        cnt_q <= CNT_W'(RST_CYCLES);
      else if (busy)
        cnt_q <= cnt_q - CNT_W'(1);

      if (wr.we_ctl) begin
        tx_q <= wdata[CTL_TX];
        wt_q <= wdata[CTL_WT_LO +: 2];
      end

      if (wipe)
        on_q <= 1'b0;
      else if (wr.we_ctl)
        on_q <= wdata[CTL_ON];

      if (wr.we_base) base_q <= wdata[REG_W-1:3];
      if (wr.we_len)  len_q  <= wdata[LEN_W-1:0];
      if (wr.we_ien)  ien_q  <= wdata[STAT_W-1:0] & STAT_MASK;

      if (wipe)
        stat_q <= '0;
      else
        stat_q <= (stat_q & ~clr_bits) | (cause & STAT_MASK);

      if (wipe || wr.we_len)
        idx_q <= '0;
      else if (adv)
        idx_q <= ((len_q == '0) || (idx_q == len_q - LEN_W'(1))) ? '0 : idx_q + LEN_W'(1);
    end
  end

  assign on_o   = on_q;
  assign tx_o   = tx_q;
  assign wt_o   = wt_q;
  assign base_o = {base_q, 3'b000};
  assign len_o  = len_q;
  assign idx_o  = idx_q;
  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign busy_o = busy;

  // R4: the end of a channel reset leaves the channel off, idle and indexed at 0
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!on_q && (stat_q == '0) && (idx_q == '0)));

  // R8: the descriptor index stays inside the ring
  a_r8_idx_in_ring: assert property (@(posedge clk) disable iff (rst)
    (len_q != '0) |-> (idx_q < len_q));

  // R8: an empty ring pins the index at 0
  a_r8_idx_empty: assert property (@(posedge clk) disable iff (rst)
    (len_q == '0) |-> (idx_q == '0));
endmodule

// File: rtl/dma_rb_glob.sv
module dma_rb_glob
  import dma_rb_pkg::*;
#(
  parameter int NCH        = 20,
  parameter int NPORT      = 5,
  parameter int RST_CYCLES = 4,
  parameter int SEL_W      = 5,
  parameter int PSEL_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  wdata,
  input  logic              we_gctl,
  input  logic              we_poll,
  input  logic              we_csel,
  input  logic              we_psel,
  input  logic              we_pctl,
  input  logic              we_gien,
  output logic [REG_W-1:0]  gctl_rd,
  output logic [REG_W-1:0]  poll_q,
  output logic [SEL_W-1:0]  csel_q,
  output logic              csel_ok,
  output logic [PSEL_W-1:0] psel_q,
  output logic [REG_W-1:0]  pctl_rd,
  output logic [NCH-1:0]    gien_q,
  output logic              eng_done
);
  localparam int ECW = $clog2(RST_CYCLES + 1);

  logic [ECW-1:0]   ecnt_q;
  logic [REG_W-1:1] gctl_hi_q;
  logic             psel_ok;
  logic [REG_W-1:0] pctl_q [NPORT];
  logic             eng_busy;

  assign eng_busy = (ecnt_q != '0);
  assign eng_done = eng_busy && (ecnt_q == ECW'(1));
  assign gctl_rd  = {gctl_hi_q, eng_busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt_q    <= '0;
      gctl_hi_q <= '0;
      poll_q    <= '0;
      csel_q    <= '0;
      csel_ok   <= 1'b1;
      psel_q    <= '0;
      psel_ok   <= 1'b1;
      gien_q    <= '0;
    end else begin
      if (we_gctl && wdata[0] && !eng_busy)
        ecnt_q <= ECW'(RST_CYCLES);
      else if (eng_busy)
        ecnt_q <= ecnt_q - ECW'(1);
      if (we_gctl) gctl_hi_q <= wdata[REG_W-1:1];
      if (we_poll) poll_q <= wdata;
      if (we_csel) begin
        csel_q  <= wdata[SEL_W-1:0];
        csel_ok <= (wdata < REG_W'(NCH));
      end
      if (we_psel) begin
        psel_q  <= wdata[PSEL_W-1:0];
        psel_ok <= (wdata < REG_W'(NPORT));
      end
      if (we_gien) gien_q <= wdata[NCH-1:0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        pctl_q[p] <= '0;
      else if (we_pctl && psel_ok && (psel_q == PSEL_W'(p)))
        pctl_q[p] <= wdata;
    end
  end

  always_comb begin
    pctl_rd = '0;
    for (int p = 0; p < NPORT; p++)
      if (psel_ok && (psel_q == PSEL_W'(p))) pctl_rd = pctl_q[p];
  end

  // R2: the channel window only moves when the select register is written
  a_r2_sel_stable: assert property (@(posedge clk) disable iff (rst)
    !we_csel |=> ($stable(csel_q) && $stable(csel_ok)));

  // R11: the engine reset countdown never exceeds its length
  a_r11_eng_bounded: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> (ecnt_q < ECW'(RST_CYCLES)) || $past(we_gctl && wdata[0] && !eng_busy));
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import dma_rb_pkg::*;
#(
  parameter int NCH        = 20,
  parameter int NPORT      = 5,
  parameter int LEN_W      = 8,
  parameter int RST_CYCLES = 4,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wen,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_ren,
  output logic [31:0]           bus_rdata,
  input  logic [STAT_W*NCH-1:0] ch_cause,
  output logic [NCH-1:0]        ch_on,
  output logic [NCH-1:0]        ch_tx,
  output logic [2*NCH-1:0]      ch_weight,
  output logic [32*NCH-1:0]     ch_base,
  output logic [LEN_W*NCH-1:0]  ch_len,
  output logic [LEN_W*NCH-1:0]  ch_idx,
  output logic                  poll_en,
  output logic                  poll_div4,
  output logic                  irq
);
  localparam int SEL_W  = $clog2(NCH);
  localparam int PSEL_W = $clog2(NPORT);

  localparam logic [ADDR_W-1:0] A_GCTL  = ADDR_W'(OFF_GCTRL);
  localparam logic [ADDR_W-1:0] A_POLL  = ADDR_W'(OFF_POLL);
  localparam logic [ADDR_W-1:0] A_CSEL  = ADDR_W'(OFF_CSEL);
  localparam logic [ADDR_W-1:0] A_CCTL  = ADDR_W'(OFF_CCTL);
  localparam logic [ADDR_W-1:0] A_CBASE = ADDR_W'(OFF_CBASE);
  localparam logic [ADDR_W-1:0] A_CLEN  = ADDR_W'(OFF_CLEN);
  localparam logic [ADDR_W-1:0] A_CSTAT = ADDR_W'(OFF_CSTAT);
  localparam logic [ADDR_W-1:0] A_CIEN  = ADDR_W'(OFF_CIEN);
  localparam logic [ADDR_W-1:0] A_PSEL  = ADDR_W'(OFF_PSEL);
  localparam logic [ADDR_W-1:0] A_PCTL  = ADDR_W'(OFF_PCTL);
  localparam logic [ADDR_W-1:0] A_GIEN  = ADDR_W'(OFF_GIEN);

  logic [REG_W-1:0]  gctl_rd, poll_q, pctl_rd;
  logic [SEL_W-1:0]  csel_q;
  logic              csel_ok, eng_done;
  logic [PSEL_W-1:0] psel_q;
  logic [NCH-1:0]    gien_q;

  logic [REG_W-1:0]  c_ctl  [NCH];
  logic [REG_W-1:0]  c_base [NCH];
  logic [LEN_W-1:0]  c_len  [NCH];
  logic [STAT_W-1:0] c_stat [NCH];
  logic [STAT_W-1:0] c_ien  [NCH];

  logic [REG_W-1:0]  s_ctl, s_base, s_len, s_stat, s_ien, rd_nxt;
  logic              irq_nxt, in_win;

  assign in_win = (bus_addr == A_CCTL) || (bus_addr == A_CBASE) || (bus_addr == A_CLEN) ||
                  (bus_addr == A_CSTAT) || (bus_addr == A_CIEN);

  dma_rb_glob #(
    .NCH(NCH), .NPORT(NPORT), .RST_CYCLES(RST_CYCLES), .SEL_W(SEL_W), .PSEL_W(PSEL_W)
  ) u_glob (
    .clk      (clk),
    .rst      (rst),
    .wdata    (bus_wdata),
    .we_gctl  (bus_wen && (bus_addr == A_GCTL)),
    .we_poll  (bus_wen && (bus_addr == A_POLL)),
    .we_csel  (bus_wen && (bus_addr == A_CSEL)),
    .we_psel  (bus_wen && (bus_addr == A_PSEL)),
    .we_pctl  (bus_wen && (bus_addr == A_PCTL)),
    .we_gien  (bus_wen && (bus_addr == A_GIEN)),
    .gctl_rd  (gctl_rd),
    .poll_q   (poll_q),
    .csel_q   (csel_q),
    .csel_ok  (csel_ok),
    .psel_q   (psel_q),
    .pctl_rd  (pctl_rd),
    .gien_q   (gien_q),
    .eng_done (eng_done)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_wr_t   w;
    logic       hit, on_c, tx_c, busy_c;
    logic [1:0] wt_c;

    assign hit       = bus_wen && csel_ok && (csel_q == SEL_W'(c));
    assign w.we_ctl  = hit && (bus_addr == A_CCTL);
    assign w.we_base = hit && (bus_addr == A_CBASE);
    assign w.we_len  = hit && (bus_addr == A_CLEN);
    assign w.we_stat = hit && (bus_addr == A_CSTAT);
    assign w.we_ien  = hit && (bus_addr == A_CIEN);

    dma_rb_chan #(.LEN_W(LEN_W), .RST_CYCLES(RST_CYCLES)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr      (w),
      .wdata   (bus_wdata),
      .cause   (ch_cause[c*STAT_W +: STAT_W]),
      .eng_clr (eng_done),
      .on_o    (on_c),
      .tx_o    (tx_c),
      .wt_o    (wt_c),
      .base_o  (c_base[c]),
      .len_o   (c_len[c]),
      .idx_o   (ch_idx[c*LEN_W +: LEN_W]),
      .stat_o  (c_stat[c]),
      .ien_o   (c_ien[c]),
      .busy_o  (busy_c)
    );

    assign c_ctl[c] = {14'b0, wt_c, 7'b0, tx_c, 6'b0, busy_c, on_c};
    assign ch_on[c]                  = on_c;
    assign ch_tx[c]                  = tx_c;
    assign ch_weight[2*c +: 2]       = wt_c;
    assign ch_base[32*c +: 32]       = c_base[c];
    assign ch_len[c*LEN_W +: LEN_W]  = c_len[c];
  end

  always_comb begin
    s_ctl  = '0;
    s_base = '0;
    s_len  = '0;
    s_stat = '0;
    s_ien  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (csel_ok && (csel_q == SEL_W'(c))) begin
        s_ctl  = c_ctl[c];
        s_base = c_base[c];
        s_len  = REG_W'(c_len[c]);
        s_stat = REG_W'(c_stat[c]);
        s_ien  = REG_W'(c_ien[c]);
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_GCTL:  rd_nxt = gctl_rd;
      A_POLL:  rd_nxt = poll_q;
      A_CSEL:  rd_nxt = REG_W'(csel_q);
      A_CCTL:  rd_nxt = s_ctl;
      A_CBASE: rd_nxt = s_base;
      A_CLEN:  rd_nxt = s_len;
      A_CSTAT: rd_nxt = s_stat;
      A_CIEN:  rd_nxt = s_ien;
      A_PSEL:  rd_nxt = REG_W'(psel_q);
      A_PCTL:  rd_nxt = pctl_rd;
      A_GIEN:  rd_nxt = REG_W'(gien_q);
      default: rd_nxt = '0;
    endcase
  end

  always_comb begin
    irq_nxt = 1'b0;
    for (int c = 0; c < NCH; c++)
      irq_nxt = irq_nxt | (gien_q[c] && ((c_stat[c] & c_ien[c]) != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_ren) bus_rdata <= rd_nxt;
      irq <= irq_nxt;
    end
  end

  assign poll_en   = poll_q[31];
  assign poll_div4 = poll_q[6];

  // R9: a cleared global enable mask keeps the interrupt low on the next cycle
  a_r9_gien_mask: assert property (@(posedge clk) disable iff (rst)
    $past(gien_q == '0) |-> !irq);

  // R10: window reads with an out-of-range select return zero
  a_r10_oob_read: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && in_win && !csel_ok) |=> (bus_rdata == '0));
endmodule

// File: tb/dma_chan_regbank_tb.sv
`timescale 1ns/1ps
module dma_chan_regbank_tb;
  localparam int NCH = 20;
  localparam int LW  = 8;
  localparam int SW  = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [11:0]       bus_addr = '0;
  logic              bus_wen = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_ren = 1'b0;
  logic [31:0]       bus_rdata;
  logic [SW*NCH-1:0] ch_cause = '0;
  logic [NCH-1:0]    ch_on, ch_tx;
  logic [2*NCH-1:0]  ch_weight;
  logic [32*NCH-1:0] ch_base;
  logic [LW*NCH-1:0] ch_len, ch_idx;
  logic              poll_en, poll_div4, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_regbank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .bus_ren(bus_ren), .bus_rdata(bus_rdata), .ch_cause(ch_cause), .ch_on(ch_on),
    .ch_tx(ch_tx), .ch_weight(ch_weight), .ch_base(ch_base), .ch_len(ch_len),
    .ch_idx(ch_idx), .poll_en(poll_en), .poll_div4(poll_div4), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Tasks start and end on a falling edge; each spans one rising edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input int c, input logic [6:0] bits);
    ch_cause[c*SW +: SW] = bits;
    @(negedge clk);
    ch_cause = '0;
  endtask

  function automatic logic [31:0] ctl_of(input int c);
    return 32'(1) | (32'(c & 1) << 8) | (32'(c & 3) << 16);
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ch_on", 32'(ch_on), 0);
    chk("R1 poll", {30'b0, poll_en, poll_div4}, 0);
    chk("R1 ch_idx0", 32'(ch_idx[LW-1:0]), 0);
    foreach (u_addrs[i]) rdchk("R1 reg reads 0", u_addrs[i], 0);

    // R2 R3 R5 R7 sweep: write every channel, then read all back
    for (int c = 0; c < NCH; c++) begin
      wr(12'h18, 32'(c));
      wr(12'h1C, ctl_of(c));
      wr(12'h20, 32'h1000_0007 + 32'(c) * 32'h100);
      wr(12'h24, 32'(c + 3));
      wr(12'h2C, 32'hFF);
    end
    for (int c = 0; c < NCH; c++) begin
      wr(12'h18, 32'(c));
      rdchk("R2 select readback", 12'h18, 32'(c));
      rdchk("R3 control readback", 12'h1C, ctl_of(c));
      rdchk("R5 base aligned", 12'h20, 32'h1000_0000 + 32'(c) * 32'h100);
      rdchk("R5 length", 12'h24, 32'(c + 3));
      rdchk("R7 enable bits 6:1", 12'h2C, 32'h7E);
      chk("R3 ch_tx", 32'(ch_tx[c]), 32'(c & 1));
      chk("R3 ch_weight", 32'(ch_weight[2*c +: 2]), 32'(c & 3));
      chk("R5 ch_base", ch_base[32*c +: 32], 32'h1000_0000 + 32'(c) * 32'h100);
      chk("R5 ch_len", 32'(ch_len[LW*c +: LW]), 32'(c + 3));
    end
    chk("R3 ch_on all", 32'(ch_on), 32'hF_FFFF);

    // R10 out-of-range select
    wr(12'h18, 32'd25);
    rdchk("R2 select low bits", 12'h18, 32'd25);
    wr(12'h1C, 32'h0);
    wr(12'h24, 32'h0);
    rdchk("R10 ctl read 0", 12'h1C, 0);
    rdchk("R10 base read 0", 12'h20, 0);
    rdchk("R10 len read 0", 12'h24, 0);
    chk("R10 ch_on untouched", 32'(ch_on), 32'hF_FFFF);
    chk("R10 ch_len0 untouched", 32'(ch_len[LW-1:0]), 3);

    // R8 descriptor index on ch2 (len 5)
    for (int k = 0; k < 7; k++) pulse(2, 7'h08);
    chk("R8 idx wraps 7 mod 5", 32'(ch_idx[2*LW +: LW]), 2);
    wr(12'h18, 32'd2);
    wr(12'h24, 32'd5);
    chk("R8 len write resets idx", 32'(ch_idx[2*LW +: LW]), 0);
    wr(12'h18, 32'd4);
    wr(12'h1C, 32'h0);
    pulse(4, 7'h08);
    chk("R8 off channel holds idx", 32'(ch_idx[4*LW +: LW]), 0);
    wr(12'h18, 32'd5);
    wr(12'h24, 32'd0);
    for (int k = 0; k < 3; k++) pulse(5, 7'h08);
    chk("R8 empty ring idx 0", 32'(ch_idx[5*LW +: LW]), 0);

    // R6 status on ch7
    wr(12'h18, 32'd2);
    rdchk("R6 ch2 desc-done status", 12'h28, 32'h08);
    pulse(7, 7'h7F);
    wr(12'h18, 32'd7);
    rdchk("R6 cause bit0 ignored", 12'h28, 32'h7E);
    wr(12'h28, 32'h0A);
    rdchk("R6 write-1-clear", 12'h28, 32'h74);
    wr(12'h28, 32'h10);
    rdchk("R6 clear bit4", 12'h28, 32'h64);
    ch_cause[7*SW +: SW] = 7'h10;
    wr(12'h28, 32'h10);
    ch_cause = '0;
    rdchk("R6 set wins over clear", 12'h28, 32'h74);

    // R9 combined interrupt
    @(negedge clk);
    chk("R9 masked by global enable 0", 32'(irq), 0);
    wr(12'hF4, 32'h4);
    @(negedge clk);
    chk("R9 ch2 enabled raises irq", 32'(irq), 1);
    rdchk("R9 global enable readback", 12'hF4, 32'h4);
    wr(12'hF4, 32'h200);
    @(negedge clk);
    chk("R9 idle channel only", 32'(irq), 0);
    wr(12'hF4, 32'h80);
    @(negedge clk);
    chk("R9 ch7 enabled", 32'(irq), 1);
    wr(12'h28, 32'h7E);
    @(negedge clk);
    chk("R9 ack drops irq", 32'(irq), 0);
    rdchk("R6 0x7E clears all", 12'h28, 0);
    wr(12'hF4, 32'h4);
    @(negedge clk);
    chk("R9 ch2 again", 32'(irq), 1);
    wr(12'hF4, 32'h0);
    @(negedge clk);
    chk("R9 write 0 masks all", 32'(irq), 0);

    // R4 channel reset on ch3
    pulse(3, 7'h08);
    chk("R4 pre idx", 32'(ch_idx[3*LW +: LW]), 1);
    wr(12'h18, 32'd3);
    wr(12'h1C, 32'h0001_0103);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      rd(12'h1C, v);
      if (v[1]) cnt++;
      else break;
    end
    chk("R4 busy read count", 32'(cnt), 4);
    rdchk("R4 ctl after reset", 12'h1C, 32'h0001_0100);
    rdchk("R4 status cleared", 12'h28, 0);
    chk("R4 idx cleared", 32'(ch_idx[3*LW +: LW]), 0);
    chk("R4 on cleared", 32'(ch_on[3]), 0);
    chk("R4 other channel on", 32'(ch_on[6]), 1);

    // R11 polling and engine reset
    wr(12'h14, 32'h8000_0040);
    chk("R11 poll bits", {30'b0, poll_en, poll_div4}, 32'h3);
    rdchk("R11 poll readback", 12'h14, 32'h8000_0040);
    wr(12'h14, 32'h0000_0040);
    chk("R11 poll off", {30'b0, poll_en, poll_div4}, 32'h1);
    pulse(2, 7'h08);
    chk("R11 pre idx ch2", 32'(ch_idx[2*LW +: LW]), 1);
    wr(12'h10, 32'h0000_0F01);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      rd(12'h10, v);
      if (v[0]) cnt++;
      else break;
    end
    chk("R11 engine busy count", 32'(cnt), 4);
    rdchk("R11 global ctl storage", 12'h10, 32'h0000_0F00);
    chk("R11 all channels off", 32'(ch_on), 0);
    chk("R11 idx cleared", 32'(ch_idx[2*LW +: LW]), 0);
    wr(12'h18, 32'd2);
    rdchk("R11 status cleared", 12'h28, 0);
    rdchk("R11 weight kept", 12'h1C, ctl_of(2) & 32'hFFFF_FFFE);

    // R12 ports and unmapped offsets
    for (int p = 0; p < 5; p++) begin
      wr(12'h40, 32'(p));
      wr(12'h44, 32'(p) * 32'h111 + 32'h5);
    end
    for (int p = 0; p < 5; p++) begin
      wr(12'h40, 32'(p));
      rdchk("R12 port control", 12'h44, 32'(p) * 32'h111 + 32'h5);
    end
    wr(12'h40, 32'd6);
    rdchk("R12 port select readback", 12'h40, 32'd6);
    wr(12'h44, 32'hDEAD);
    rdchk("R12 bad port read 0", 12'h44, 0);
    wr(12'h40, 32'd1);
    rdchk("R12 port1 unchanged", 12'h44, 32'h116);
    wr(12'h30, 32'hFFFF_FFFF);
    rdchk("R12 unmapped read 0", 12'h30, 0);
    rdchk("R12 neighbour unchanged", 12'h2C, 32'h7E);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [11:0] u_addrs [11] = '{12'h10, 12'h14, 12'h18, 12'h1C, 12'h20, 12'h24,
                               12'h28, 12'h2C, 12'h40, 12'h44, 12'hF4};
endmodule